// File: doc/BRIEF.md
# Bus Manager Transfer Issuer with Selectable Error Policy

This block is the address and data phase sequencer of a single-word AHB-Lite manager. A local client hands it one read or write at a time over a valid/ready command port. The block places each command in the address phase as a NONSEQ transfer and then carries it through the data phase. When the command leaves the address phase it drives the write data, and when the subordinate signals ready it returns a completion carrying the status and the read data. Address and data phases overlap, so one command can wait in the address phase while the one before it is still in its data phase.

Every command carries its own policy for a two-cycle ERROR response. Under the cancel policy, the command waiting behind an erroring transfer is withdrawn from the address phase in the first error cycle and returned as cancelled. Under the continue policy, the first error cycle is treated like a wait state, and a new command may even enter an empty address phase during that cycle. A command marked as a protection or access-violation class always uses the cancel policy, and its error completion carries a fault flag.

Back-pressure rules: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Once `cmd_valid` is raised, the client must hold it and the command fields steady until that edge. The completion port has no ready signal. `rsp_valid` is a single-cycle pulse, and the client must be able to take one completion in every cycle.

Top module: `ahb_err_mgr`

## Requirements
- R1: While reset is asserted and after its release, `htrans` is IDLE, `rsp_valid` is low and no command is held in either phase.
- R2: `htrans` only ever carries IDLE (2'b00) or NONSEQ (2'b10) and never 2'b11 or 2'b01. `hsize` is 3'b010 for the 32-bit data width.
- R3: `cmd_ready` is high whenever `hready` is high. During an OKAY wait cycle (`hready`=0, `hresp`=0), `cmd_ready` is low.
- R4: In an OKAY wait cycle, `haddr` and `hwrite` keep their values into the next cycle, and `htrans` does not change unless `hresp` rises.
- R5: For a write, `hwdata` holds the command's write data for the whole data phase, including the cycle in which `hready` is high.
- R6: An ERROR response is one cycle with `hresp`=1, `hready`=0, followed by one cycle with `hresp`=1, `hready`=1. The data phase ends only in the second cycle, and the completion reports ERROR (status 2'b01).
- R7: Under the cancel policy (`cmd_continue`=0), `htrans` is IDLE in the first error cycle. The command that was in the address phase then completes with CANCELLED (2'b10) and never appears on the bus again.
- R8: Under the continue policy (`cmd_continue`=1), the command already in the address phase stays NONSEQ through the error. If the address phase is empty, `cmd_ready` is high in the first error cycle, and a command taken there is driven as NONSEQ in the second error cycle.
- R9: A command with `cmd_violation`=1 uses the cancel policy whatever `cmd_continue` says. Its ERROR completion has `rsp_fault`=1. Every other completion has `rsp_fault`=0.
- R10: Each accepted command produces exactly one `rsp_valid` pulse, in acceptance order. OKAY is 2'b00. A read that completes with OKAY returns `hrdata` on `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this edge when high with cmd_valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write data |
| cmd_continue | input | 1 | Error policy: 1 = continue as wait, 0 = cancel |
| cmd_violation | input | 1 | Protection or access-violation class; forces cancel |
| rsp_valid | output | 1 | Completion pulse |
| rsp_status | output | 2 | 00 OKAY, 01 ERROR, 10 CANCELLED |
| rsp_rdata | output | DW | Read data on OKAY reads, else zero |
| rsp_fault | output | 1 | Error completion of a violation-class command |
| htrans | output | 2 | Transfer type |
| haddr | output | AW | Transfer address |
| hwrite | output | 1 | Transfer direction |
| hsize | output | 3 | Transfer size (full word) |
| hwdata | output | DW | Write data for the data phase |
| hrdata | input | DW | Read data from the subordinate |
| hready | input | 1 | Transfer done / bus ready |
| hresp | input | 1 | 1 = ERROR response |

## Verification
The bench builds the block with AW=16 and DW=32. Because the data width is twice the address width, every write datum and every read datum can be derived from its address. The bench subordinate also reads its behaviour from address bits: the wait count (0 to 3) from bits 5:4, the error response from bit 8, the continue policy from bit 9 and the violation class from bit 10. This lets each command script its own waits, errors and policy, and puts every combination within reach: an error after waits, back-to-back errors, a cancel followed by recovery, a violation overriding a continue request, and a command entering an empty address phase in mid-error.

// File: rtl/ahb_err_pkg.sv
package ahb_err_pkg;
  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_NONSEQ = 2'b10
  } htrans_e;

  typedef enum logic [1:0] {
    ST_OKAY   = 2'b00,
    ST_ERROR  = 2'b01,
    ST_CANCEL = 2'b10
  } rsp_status_e;
endpackage

// File: rtl/ahb_err_policy.sv
module ahb_err_policy (
  input  logic hready_i,
  input  logic hresp_i,
  input  logic d_cancel_i,
  input  logic a_valid_i,
  output logic err1_o,
  output logic kill_o,
  output logic cmd_ready_o
);
  // first error cycle: error signalled while the data phase is still open
  assign err1_o      = hresp_i && !hready_i;
  assign kill_o      = err1_o && d_cancel_i;
  // continue policy lets an empty address phase fill during the first error cycle
  assign cmd_ready_o = hready_i || (err1_o && !d_cancel_i && !a_valid_i);
endmodule

// File: rtl/ahb_addr_stage.sv
module ahb_addr_stage
  import ahb_err_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          advance_i,
  input  logic          kill_i,
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cont_i,
  input  logic          viol_i,
  output logic          valid_o,
  output logic          killed_o,
  output logic [AW-1:0] addr_o,
  output logic          write_o,
  output logic [DW-1:0] wdata_o,
  output logic          cont_o,
  output logic          viol_o,
  output logic [1:0]    htrans_o
);
  logic          valid_q, killed_q, write_q, cont_q, viol_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      killed_q <= 1'b0;
      addr_q   <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      cont_q   <= 1'b0;
      viol_q   <= 1'b0;
    end else if (load_i) begin
      valid_q  <= 1'b1;
      killed_q <= 1'b0;
      addr_q   <= addr_i;
      write_q  <= write_i;
      wdata_q  <= wdata_i;
      cont_q   <= cont_i;
      viol_q   <= viol_i;
    end else if (advance_i) begin
      valid_q  <= 1'b0;
      killed_q <= 1'b0;
    end else if (kill_i && valid_q) begin
      killed_q <= 1'b1;
    end
  end

  always_comb begin
    if (valid_q && !killed_q && !kill_i) htrans_o = HT_NONSEQ;
    else                                 htrans_o = HT_IDLE;
  end

  assign valid_o  = valid_q;
  assign killed_o = killed_q;
  assign addr_o   = addr_q;
  assign write_o  = write_q;
  assign wdata_o  = wdata_q;
  assign cont_o   = cont_q;
  assign viol_o   = viol_q;

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !advance_i |=> valid_q && $stable(addr_q) && $stable(write_q));
endmodule

// File: rtl/ahb_data_stage.sv
module ahb_data_stage
  import ahb_err_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready_i,
  input  logic          hresp_i,
  input  logic [DW-1:0] hrdata_i,
  input  logic          cap_i,
  input  logic          cap_killed_i,
  input  logic          cap_write_i,
  input  logic [DW-1:0] cap_wdata_i,
  input  logic          cap_cont_i,
  input  logic          cap_viol_i,
  output logic          valid_o,
  output logic          cancel_o,
  output logic [DW-1:0] hwdata_o,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_status_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_fault_o
);
  logic          valid_q, killed_q, write_q, cont_q, viol_q;
  logic [DW-1:0] wdata_q;
  logic          rsp_valid_q, rsp_fault_q;
  logic [1:0]    rsp_status_q;
  logic [DW-1:0] rsp_rdata_q;

  rsp_status_e   st_n;
  logic [DW-1:0] rd_n;
  logic          flt_n;

  always_comb begin
    st_n  = ST_OKAY;
    rd_n  = '0;
    flt_n = 1'b0;
    if (killed_q) begin
      st_n = ST_CANCEL;
    end else if (hresp_i) begin
      st_n  = ST_ERROR;
      flt_n = viol_q;
    end else if (!write_q) begin
      rd_n = hrdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q      <= 1'b0;
      killed_q     <= 1'b0;
      write_q      <= 1'b0;
      wdata_q      <= '0;
      cont_q       <= 1'b0;
      viol_q       <= 1'b0;
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= ST_OKAY;
      rsp_rdata_q  <= '0;
      rsp_fault_q  <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      if (hready_i) begin
        if (valid_q) begin
          rsp_valid_q  <= 1'b1;
          rsp_status_q <= st_n;
          rsp_rdata_q  <= rd_n;
          rsp_fault_q  <= flt_n;
        end
        valid_q <= cap_i;
        if (cap_i) begin
          killed_q <= cap_killed_i;
          write_q  <= cap_write_i;
          wdata_q  <= cap_wdata_i;
          cont_q   <= cap_cont_i;
          viol_q   <= cap_viol_i;
        end
      end
    end
  end

  assign valid_o      = valid_q;
  assign cancel_o     = valid_q && !killed_q && (!cont_q || viol_q);
  assign hwdata_o     = wdata_q;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_status_o = rsp_status_q;
  assign rsp_rdata_o  = rsp_rdata_q;
  assign rsp_fault_o  = rsp_fault_q;

  // R5
  hwdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !hready_i |=> $stable(hwdata_o));

  // R9
  fault_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_o |-> rsp_valid_o && rsp_status_o == ST_ERROR);
endmodule

// File: rtl/ahb_err_mgr.sv
module ahb_err_mgr
  import ahb_err_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          cmd_continue,
  input  logic          cmd_violation,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_fault,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready,
  input  logic          hresp
);
  localparam int SIZE_CODE = $clog2(DW / 8);

  logic          err1, kill, load;
  logic          a_valid, a_killed, a_write, a_cont, a_viol;
  logic [DW-1:0] a_wdata;
  logic          d_valid, d_cancel;

  assign load  = cmd_valid && cmd_ready;
  assign hsize = 3'(SIZE_CODE);

  ahb_err_policy u_policy (
    .hready_i    (hready),
    .hresp_i     (hresp),
    .d_cancel_i  (d_cancel),
    .a_valid_i   (a_valid),
    .err1_o      (err1),
    .kill_o      (kill),
    .cmd_ready_o (cmd_ready)
  );

  ahb_addr_stage #(.AW(AW), .DW(DW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .advance_i (hready),
    .kill_i    (kill),
    .addr_i    (cmd_addr),
    .write_i   (cmd_write),
    .wdata_i   (cmd_wdata),
    .cont_i    (cmd_continue),
    .viol_i    (cmd_violation),
    .valid_o   (a_valid),
    .killed_o  (a_killed),
    .addr_o    (haddr),
    .write_o   (a_write),
    .wdata_o   (a_wdata),
    .cont_o    (a_cont),
    .viol_o    (a_viol),
    .htrans_o  (htrans)
  );

  assign hwrite = a_write;

  ahb_data_stage #(.DW(DW)) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .hready_i     (hready),
    .hresp_i      (hresp),
    .hrdata_i     (hrdata),
    .cap_i        (a_valid),
    .cap_killed_i (a_killed || kill),
    .cap_write_i  (a_write),
    .cap_wdata_i  (a_wdata),
    .cap_cont_i   (a_cont),
    .cap_viol_i   (a_viol),
    .valid_o      (d_valid),
    .cancel_o     (d_cancel),
    .hwdata_o     (hwdata),
    .rsp_valid_o  (rsp_valid),
    .rsp_status_o (rsp_status),
    .rsp_rdata_o  (rsp_rdata),
    .rsp_fault_o  (rsp_fault)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> htrans == HT_IDLE && !rsp_valid);

  // R2
  no_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == HT_IDLE || htrans == HT_NONSEQ);

  // R7
  cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err1 && d_cancel |-> htrans == HT_IDLE);

  // R8
  continue_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err1 && d_valid && !d_cancel && a_valid && !a_killed |-> htrans == HT_NONSEQ);
endmodule

// File: tb/ahb_err_mgr_tb.sv
module ahb_err_mgr_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_ready, cmd_write, cmd_continue, cmd_violation;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          rsp_valid, rsp_fault;
  logic [1:0]    rsp_status, htrans;
  logic [DW-1:0] rsp_rdata, hwdata, hrdata;
  logic [AW-1:0] haddr;
  logic          hwrite, hready, hresp;
  logic [2:0]    hsize;

  always #5 clk = ~clk;

  ahb_err_mgr #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_continue(cmd_continue), .cmd_violation(cmd_violation),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .rsp_fault(rsp_fault), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
    .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    st;
    logic          flt;
    logic          wr;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0, errors = 0;
  int   bus_accepts = 0, expect_accepts = 0;
  bit   prev_kill = 1'b0, finished = 1'b0, running = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bits 3:0 id, 5:4 waits, 8 error, 9 continue, 10 violation
  function automatic logic [AW-1:0] mk(int id, int w, bit e, bit c, bit v);
    logic [AW-1:0] a;
    a = '0;
    a[3:0] = id[3:0];
    a[5:4] = w[1:0];
    a[8] = e; a[9] = c; a[10] = v;
    return a;
  endfunction

  function automatic exp_t predict(logic [AW-1:0] a, logic wr);
    exp_t e;
    e.addr = a; e.wr = wr;
    e.st   = prev_kill ? 2'b10 : (a[8] ? 2'b01 : 2'b00);
    e.flt  = (e.st == 2'b01) && a[10];
    prev_kill = (e.st != 2'b10) && a[8] && (!a[9] || a[10]);
    if (e.st != 2'b10) expect_accepts++;
    return e;
  endfunction

  task automatic drive(logic [AW-1:0] a, logic wr);
    cmd_valid = 1'b1; cmd_addr = a; cmd_write = wr;
    cmd_wdata = {a, ~a}; cmd_continue = a[9]; cmd_violation = a[10];
  endtask

  task automatic send(logic [AW-1:0] a, logic wr);
    bit acc;
    sb_q.push_back(predict(a, wr));
    drive(a, wr);
    do begin
      #1 acc = cmd_ready;
      @(negedge clk);
    end while (!acc);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    prev_kill = 1'b0;
  endtask

  // subordinate model
  logic          s_ready, s_resp, dp_act, dp_write, s_err;
  logic [AW-1:0] dp_addr;
  int            s_cnt;
  assign hready = s_ready;
  assign hresp  = s_resp;
  assign hrdata = {~dp_addr, dp_addr};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ready <= 1'b1; s_resp <= 1'b0; dp_act <= 1'b0; dp_write <= 1'b0;
      dp_addr <= '0; s_cnt <= 0; s_err <= 1'b0;
    end else if (s_ready) begin
      if (htrans == 2'b10) begin
        bus_accepts <= bus_accepts + 1;
        dp_act <= 1'b1; dp_addr <= haddr; dp_write <= hwrite; s_err <= haddr[8];
        if (haddr[5:4] != 2'b00) begin
          s_ready <= 1'b0; s_resp <= 1'b0; s_cnt <= int'(haddr[5:4]) - 1;
        end else if (haddr[8]) begin
          s_ready <= 1'b0; s_resp <= 1'b1;
        end else begin
          s_ready <= 1'b1; s_resp <= 1'b0;
        end
      end else begin
        dp_act <= 1'b0; s_ready <= 1'b1; s_resp <= 1'b0;
      end
    end else if (s_resp) begin
      s_ready <= 1'b1;
    end else if (s_cnt != 0) begin
      s_cnt <= s_cnt - 1;
    end else if (s_err) begin
      s_resp <= 1'b1;
    end else begin
      s_ready <= 1'b1;
    end
  end

  // monitor and scoreboard
  logic          pw_wait;
  logic [1:0]    pw_ht;
  logic [AW-1:0] pw_ad;
  always @(negedge clk) begin
    if (running) begin
      if (htrans == 2'b10) chk(hsize == 3'b010, "R2 hsize", hsize, 3'b010);
      if (htrans == 2'b11 || htrans == 2'b01) chk(1'b0, "R2 htrans", htrans, 2'b10);
      if (!hready && !hresp) chk(!cmd_ready, "R3 ready in wait", cmd_ready, 0);
      if (pw_wait && pw_ht == 2'b10)
        chk(haddr == pw_ad && (hresp || htrans == pw_ht), "R4 hold", haddr, pw_ad);
      if (dp_act && dp_write && hready)
        chk(hwdata == {dp_addr, ~dp_addr}, "R5 hwdata", hwdata, {dp_addr, ~dp_addr});
      if (dp_act && hresp && !hready && (!dp_addr[9] || dp_addr[10]))
        chk(htrans == 2'b00, dp_addr[10] ? "R9 forced cancel" : "R7 idle in err1", htrans, 0);
      if (rsp_valid) begin
        if (sb_q.size() == 0) chk(1'b0, "R10 extra completion", rsp_status, 0);
        else begin
          exp_t e;
          string tg;
          e = sb_q.pop_front();
          tg = (e.st == 2'b10) ? "R7 status" : (e.st == 2'b01) ? "R6 status" : "R10 status";
          chk(rsp_status == e.st, tg, {e.addr, 14'd0, rsp_status}, {e.addr, 14'd0, e.st});
          chk(rsp_fault == e.flt, "R9 fault", rsp_fault, e.flt);
          if (e.st == 2'b00 && !e.wr)
            chk(rsp_rdata == {~e.addr, e.addr}, "R10 rdata", rsp_rdata, {~e.addr, e.addr});
        end
      end
    end
    pw_wait = !hready && !hresp;
    pw_ht   = htrans;
    pw_ad   = haddr;
  end

  initial begin
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    cmd_continue = 1'b0; cmd_violation = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(htrans == 2'b00, "R1 htrans", htrans, 0);
    chk(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);
    chk(cmd_ready, "R3 ready after reset", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1'b1;

    // plain traffic, mixed waits and directions (R4, R5, R10)
    for (int i = 0; i < 12; i++) send(mk(i, i % 4, 1'b0, 1'b0, 1'b0), i[0]);
    drain();

    // cancel policy (R6, R7)
    send(mk(1, 1, 1'b1, 1'b0, 1'b0), 1'b1);
    send(mk(2, 0, 1'b0, 1'b0, 1'b0), 1'b0);
    send(mk(3, 2, 1'b0, 1'b0, 1'b0), 1'b1);
    send(mk(4, 0, 1'b1, 1'b0, 1'b0), 1'b0);
    send(mk(5, 0, 1'b0, 1'b0, 1'b0), 1'b1);
    drain();

    // continue policy with a queued command (R8)
    send(mk(6, 1, 1'b1, 1'b1, 1'b0), 1'b0);
    send(mk(7, 0, 1'b0, 1'b0, 1'b0), 1'b0);
    send(mk(8, 0, 1'b1, 1'b1, 1'b0), 1'b1);
    send(mk(9, 3, 1'b0, 1'b0, 1'b0), 1'b0);
    drain();

    // violation overrides continue (R9)
    send(mk(10, 0, 1'b1, 1'b1, 1'b1), 1'b0);
    send(mk(11, 0, 1'b0, 1'b0, 1'b0), 1'b1);
    drain();

    // continue policy, empty address phase: IDLE to NONSEQ in mid-error (R8)
    send(mk(12, 0, 1'b1, 1'b1, 1'b0), 1'b0);
    while (!(hresp && !hready)) @(negedge clk);
    begin
      logic [AW-1:0] q;
      q = mk(13, 0, 1'b0, 1'b0, 1'b0);
      sb_q.push_back(predict(q, 1'b0));
      drive(q, 1'b0);
      #1 chk(cmd_ready, "R8 ready in err1", cmd_ready, 1);
      @(negedge clk);
      chk(htrans == 2'b10 && haddr == q, "R8 nonseq in err2", {htrans, haddr}, {2'b10, q});
      cmd_valid = 1'b0;
    end
    drain();

    chk(bus_accepts == expect_accepts, "R7 no reissue", bus_accepts, expect_accepts);
    chk(sb_q.size() == 0, "R10 all completed", sb_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule